// File: doc/BRIEF.md
# Addressable Tap Shift Register

This block is a serial delay line with a fixed chain of sixteen one-bit stages. A rising clock edge with the shift enable high pushes the serial input bit into stage 0, and every other stage takes the value of the stage below it. With the enable low the chain holds its contents whatever the clock does.

A run-time tap address picks which stage drives the single output. Address value `n` gives a delay of `n + 1` enabled clock edges, so any delay from 1 to 16 is available. The address only steers a multiplexer: changing it moves the output at once, with no clock edge, and leaves the stored bits alone.

There is no reset input. The chain starts from a 16-bit parameter. Bit `i` of the parameter is the starting value of stage `i`, so the most significant hex digit covers stages 15 down to 12. When the parameter is not overridden, every stage starts at zero.

Top module: `tapsr_top`

## Requirements
- R1: With the enable held high and tap address `n`, a bit presented at the serial input appears at the output after exactly `n + 1` rising clock edges (address 0 gives 1, address 15 gives 16).
- R2: Before any enabled edge, the output at tap address `n` equals bit `n` of the start-value parameter, for every `n` from 0 to 15.
- R3: When the start-value parameter is left at its default, every stage reads 0 before any enabled edge.
- R4: A rising edge with the enable low changes no stage: every tap reads back the same value after such edges, whatever the serial input is doing.
- R5: On a rising edge with the enable high, stage 0 takes the serial input and stage `i` takes the old value of stage `i-1`, for `i` from 1 to 15.
- R6: The output always equals the stage picked by the current tap address and follows an address change without a clock edge. Changing the address never alters any stored stage.
- R7: Under any mix of enabled and idle edges, with the tap address changed between edges, the output matches a 16-deep delay-line model at every sample.
- R8: The start-value parameter is read as a 16-bit number whose most significant bit seeds stage 15 and whose least significant bit seeds stage 0 (for 16'hA5C3 stage 15 reads 1, stage 14 reads 0, stage 1 reads 1 and stage 0 reads 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| shift_en | input | 1 | High: shift on this edge; low: hold all stages |
| ser_in | input | 1 | Serial bit that enters stage 0 |
| tap_sel | input | 4 | Stage number that drives the output (delay minus one) |
| tap_out | output | 1 | Value of the selected stage |

## Verification
The output has two timing paths. After an enabled edge, the new contents show at the output within that edge, so the bench samples a quarter period after the edge. After an address change, the output settles with no edge at all, so the bench waits one time unit and samples while the enable is already low. The enable is dropped just after every edge the bench means to use, so the stray edges during an address sweep change nothing. Expected values come from a bench-side shift model that is updated only on the edges where the bench drove the enable high.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;

    // Number of stages in the chain; the tap address width follows from it.
    localparam int TAPSR_DEPTH = 16;

    // One shift request as seen on a clock edge.
    typedef struct packed {
        logic advance;   // shift on this edge
        logic bit_in;    // bit that enters stage 0
    } shift_cmd_t;

    // Next chain value for a given request.
    function automatic logic [TAPSR_DEPTH-1:0] next_chain(
        input logic [TAPSR_DEPTH-1:0] cur,
        input shift_cmd_t             cmd
    );
        if (cmd.advance) begin
            return {cur[TAPSR_DEPTH-2:0], cmd.bit_in};
        end
        return cur;
    endfunction

endpackage

// File: rtl/tapsr_chain.sv
module tapsr_chain
    import tapsr_pkg::*;
#(
    parameter int                     DEPTH    = TAPSR_DEPTH,
    parameter logic [DEPTH-1:0]       INIT_VAL = '0
) (
    input  logic             clk,
    input  shift_cmd_t       cmd,
    output logic [DEPTH-1:0] stages
);

    // No reset: the chain starts from the parameter value.
    logic [DEPTH-1:0] chain_r = INIT_VAL;

    always_ff @(posedge clk) begin
        chain_r <= next_chain(chain_r, cmd);
    end

    assign stages = chain_r;

endmodule

// File: rtl/tapsr_mux.sv
module tapsr_mux #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]  stages,
    input  logic [ADDR_W-1:0] sel,
    output logic              tap
);

    // One-hot decode of the address, gated with each stage, then OR-reduced.
    logic [DEPTH-1:0] hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
        assign hit[i] = stages[i] & (sel == ADDR_W'(i));
    end

    assign tap = |hit;

endmodule

// File: rtl/tapsr_top.sv
module tapsr_top
    import tapsr_pkg::*;
#(
    parameter int               DEPTH    = TAPSR_DEPTH,
    parameter logic [DEPTH-1:0] INIT_VAL = '0,
    localparam int              ADDR_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic              ser_in,
    input  logic [ADDR_W-1:0] tap_sel,
    output logic              tap_out
);

    shift_cmd_t       cmd;
    logic [DEPTH-1:0] chain_q;

    assign cmd.advance = shift_en;
    assign cmd.bit_in  = ser_in;

    tapsr_chain #(
        .DEPTH    (DEPTH),
        .INIT_VAL (INIT_VAL)
    ) chain_i (
        .clk    (clk),
        .cmd    (cmd),
        .stages (chain_q)
    );

    tapsr_mux #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) mux_i (
        .stages (chain_q),
        .sel    (tap_sel),
        .tap    (tap_out)
    );

endmodule

// File: rtl/tapsr_chk.sv
module tapsr_chk #(
    parameter int               DEPTH    = 16,
    parameter logic [DEPTH-1:0] INIT_VAL = '0,
    parameter int               ADDR_W   = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              shift_en,
    input logic              ser_in,
    input logic [ADDR_W-1:0] tap_sel,
    input logic              tap_out,
    input logic [DEPTH-1:0]  chain
);

    // Without a reset, properties are held off until one edge has passed.
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    always @(posedge clk) begin
        if (!armed) begin
            AST_POWERUP_VALUE: assert (chain == INIT_VAL); // R2
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!armed)
        !shift_en |=> $stable(chain)); // R4

    AST_STAGE0_LOAD: assert property (@(posedge clk) disable iff (!armed)
        shift_en |=> chain[0] == $past(ser_in)); // R5

    AST_STAGES_MOVE_UP: assert property (@(posedge clk) disable iff (!armed)
        shift_en |=> chain[DEPTH-1:1] == $past(chain[DEPTH-2:0])); // R5

    AST_TAP_MATCHES_STAGE: assert property (@(posedge clk) disable iff (!armed)
        tap_out == chain[tap_sel]); // R6

    AST_FIRST_TAP_DELAY: assert property (@(posedge clk) disable iff (!armed)
        (shift_en && tap_sel == '0) |=> (tap_sel != '0) || (tap_out == $past(ser_in))); // R1

endmodule

bind tapsr_top tapsr_chk #(
    .DEPTH    (DEPTH),
    .INIT_VAL (INIT_VAL),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk      (clk),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .tap_sel  (tap_sel),
    .tap_out  (tap_out),
    .chain    (chain_q)
);

// File: tb/tapsr_top_tb_top.sv
module tapsr_top_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          DEPTH      = 16;
    localparam logic [15:0] START_VAL  = 16'hA5C3;
    localparam int          WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       shift_en = 1'b0;
    logic       ser_in = 1'b0;
    logic [3:0] tap_sel = 4'd0;
    logic       tap_out;
    logic       tap_out_zero;

    logic [15:0] model = START_VAL;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tapsr_top #(.INIT_VAL(START_VAL)) dut_i (
        .clk(clk), .shift_en(shift_en), .ser_in(ser_in),
        .tap_sel(tap_sel), .tap_out(tap_out)
    );

    tapsr_top dut_zero_i (
        .clk(clk), .shift_en(1'b0), .ser_in(1'b0),
        .tap_sel(tap_sel), .tap_out(tap_out_zero)
    );

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s tap=%0d actual=%b expected=%b t=%0t", req, tap_sel, act, exp, $time);
        end
    endtask

    // Change the address while the enable is low and let the mux settle.
    task automatic set_addr(input int a);
        tap_sel = 4'(a);
        #1;
    endtask

    // One edge; the enable is dropped right after it so later edges do nothing.
    task automatic tick(input logic en, input logic d);
        @(negedge clk);
        shift_en = en;
        ser_in   = d;
        @(posedge clk);
        if (en) model = {model[14:0], d};
        #1;
        shift_en = 1'b0;
        #(CLK_PERIOD/4);
    endtask

    task automatic sweep_all(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            set_addr(a);
            check_bit(req, tap_out, model[a]);
        end
    endtask

    task automatic test_powerup();
        for (int a = 0; a < DEPTH; a++) begin
            set_addr(a);
            check_bit("R2", tap_out, START_VAL[a]);
            check_bit("R3", tap_out_zero, 1'b0);
        end
        set_addr(15); check_bit("R8", tap_out, 1'b1);
        set_addr(14); check_bit("R8", tap_out, 1'b0);
        set_addr(1);  check_bit("R8", tap_out, 1'b1);
        set_addr(0);  check_bit("R8", tap_out, 1'b1);
    endtask

    task automatic test_addr_no_disturb();
        for (int a = DEPTH - 1; a >= 0; a--) begin
            set_addr(a);
            check_bit("R6", tap_out, model[a]);
        end
        sweep_all("R6");
    endtask

    task automatic test_fixed_delay();
        for (int a = 0; a < DEPTH; a++) begin
            set_addr(a);
            for (int k = 0; k < DEPTH; k++) tick(1'b1, 1'b0);
            for (int k = 1; k <= DEPTH + 1; k++) begin
                tick(1'b1, (k == 1));
                check_bit("R1", tap_out, (k == a + 1));
            end
        end
    endtask

    task automatic test_enable_hold();
        for (int k = 0; k < DEPTH; k++) tick(1'b1, k[0] ^ k[2]);
        sweep_all("R4");
        for (int k = 0; k < 6; k++) tick(1'b0, k[0]);
        sweep_all("R4");
    endtask

    task automatic test_shift();
        logic prev;
        for (int k = 0; k < 8; k++) begin
            prev = model[0];
            tick(1'b1, k[1]);
            set_addr(0); check_bit("R5", tap_out, k[1]);
            set_addr(1); check_bit("R5", tap_out, prev);
        end
    endtask

    task automatic test_random();
        for (int k = 0; k < 400; k++) begin
            tap_sel = 4'($urandom_range(0, 15));
            tick(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            check_bit("R7", tap_out, model[tap_sel]);
            set_addr($urandom_range(0, 15));
            check_bit("R7", tap_out, model[tap_sel]);
        end
    endtask

    initial begin
        test_powerup();
        test_addr_no_disturb();
        test_fixed_delay();
        test_enable_hold();
        test_shift();
        test_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule